// File: doc/BRIEF.md
# Julia Set Pixel Iteration Engine

This block generates a fractal image as a stream of pixels. After a start pulse it walks a rectangular grid of pixels, one row after another. For each pixel it takes the complex point `z` given by the pixel's position inside a fixed square window running from -1.5 to +1.5 on both axes. It then applies the quadratic map `z <- z*z + c` once per clock cycle. It stops when `|z|^2` grows past 4 or when the iteration cap is reached. The number of iterations becomes an 8-bit grey level, placed on all three colour channels.

All arithmetic is signed fixed point. The format has 16 bits with 12 fraction bits, so 1.0 is 4096. The caller supplies the per-pixel step sizes in that same format, which means the block needs no divider. The caller also supplies the real and imaginary parts of the constant `c`. Different constants give different shapes. A typical default is `c = 0.123 + 0.745i`, which is about (504, 3052).

Each result leaves on a valid/ready handshake together with its column and row index. A one-cycle done pulse marks the end of the frame.

Top module: `julia_engine`

## Requirements
- R1: Pixel (m, n) starts from z0 = (-6144 + m*step_x, -6144 + n*step_y) in the 16-bit format with 12 fraction bits, where -6144 stands for -1.5. The step values and the constant are sampled when start is accepted.
- R2: Pixels are emitted in row-major order. The column index `pix_x` runs 0..width-1 fastest, and the row index `pix_y` runs 0..height-1. Width and height must each be at least 1.
- R3: One iteration computes sx = (x*x)>>>12, sy = (y*y)>>>12 and xy2 = (x*y)>>>11, each with floor rounding. It then sets x' = sx - sy + c_re and y' = xy2 + c_im, both truncated to 16 bits. Both x' and y' are formed from the old x and y.
- R4: The test sx + sy <= 16384 (4.0) is made before each update. A pixel whose z0 already fails the test reports a count of 0.
- R5: Iteration stops at a count of 255 even if the point has not escaped.
- R6: `pix_r`, `pix_g` and `pix_b` all carry the final count.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x`, `pix_y` and the colour outputs hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the last pixel is accepted. `pix_valid` is low in that cycle.
- R9: A start pulse while a frame is in progress has no effect. Changes on the width, height, step and constant inputs after start is accepted do not affect the frame in progress.
- R10: While the asynchronous active-low reset `rst_n` is low, `pix_valid` and `done` are low. After reset the block idles until start.
- R11: The engine performs one iteration per clock cycle. With `pix_ready` held high, a pixel whose count is k becomes valid k+2 cycles after the start edge (for the first pixel) or after the previous acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame; accepted only when idle |
| width | input | 10 | Pixels per row |
| height | input | 10 | Rows per frame |
| step_x | input | 16 | Real-axis increment per column, signed fixed point |
| step_y | input | 16 | Imaginary-axis increment per row, signed fixed point |
| c_re | input | 16 | Real part of the map constant |
| c_im | input | 16 | Imaginary part of the map constant |
| pix_valid | output | 1 | Pixel result available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_x | output | 10 | Column index of the pixel |
| pix_y | output | 10 | Row index of the pixel |
| pix_r | output | 8 | Red channel (iteration count) |
| pix_g | output | 8 | Green channel (iteration count) |
| pix_b | output | 8 | Blue channel (iteration count) |
| done | output | 1 | One-cycle pulse after the final pixel is accepted |

## Verification
On every cycle, the bound assertions check several properties. The output hold under back-pressure, equal colour channels, coordinates inside the latched frame size, the single-cycle done pulse with valid low, and the rule that the count grows by exactly one per unfinished iteration cycle all hold by property. The numeric correctness of each count against the fixed-point recurrence, the row-major coordinate sequence, the escape-before-update and cap corner cases, the start-ignored-while-busy behaviour and the per-pixel cycle latency can only be shown by the bench. It does this by sweeping small frames against its own model of the arithmetic.

// File: rtl/julia_pkg.sv
package julia_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_OUT  = 2'd2,
      ST_DONE = 2'd3
   } eng_state_e;

   localparam int NUM_CHAN = 3;

endpackage

// File: rtl/julia_scan.sv
module julia_scan #(
   parameter int DATA_W  = 16,
   parameter int FRAC_W  = 12,
   parameter int COORD_W = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic                      advance,
   input  logic [COORD_W-1:0]        cols,
   input  logic [COORD_W-1:0]        rows,
   input  logic signed [DATA_W-1:0]  inc_x,
   input  logic signed [DATA_W-1:0]  inc_y,
   output logic [COORD_W-1:0]        col_idx,
   output logic [COORD_W-1:0]        row_idx,
   output logic signed [DATA_W-1:0]  nxt_re,
   output logic signed [DATA_W-1:0]  nxt_im,
   output logic                      at_last
);

   localparam int WIN_MIN_I = -(3 * (1 << (FRAC_W - 1)));
   localparam logic signed [DATA_W-1:0] WIN_MIN = WIN_MIN_I[DATA_W-1:0];

   logic [COORD_W-1:0]       col_q, row_q, col_d, row_d;
   logic signed [DATA_W-1:0] re_q, im_q, re_d, im_d;
   logic                     row_end;

   assign row_end = (col_q == cols - 1'b1);
   assign at_last = row_end && (row_q == rows - 1'b1);

   always_comb begin
      col_d = col_q;
      row_d = row_q;
      re_d  = re_q;
      im_d  = im_q;
      if (restart) begin
         col_d = '0;
         row_d = '0;
         re_d  = WIN_MIN;
         im_d  = WIN_MIN;
      end else if (advance) begin
         if (row_end) begin
            col_d = '0;
            row_d = row_q + 1'b1;
            re_d  = WIN_MIN;
            im_d  = im_q + inc_y;
         end else begin
            col_d = col_q + 1'b1;
            re_d  = re_q + inc_x;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
         re_q  <= WIN_MIN;
         im_q  <= WIN_MIN;
      end else begin
         col_q <= col_d;
         row_q <= row_d;
         re_q  <= re_d;
         im_q  <= im_d;
      end
   end

   assign col_idx = col_q;
   assign row_idx = row_q;
   assign nxt_re  = re_d;
   assign nxt_im  = im_d;

endmodule

// File: rtl/julia_iter.sv
module julia_iter #(
   parameter int DATA_W = 16,
   parameter int FRAC_W = 12,
   parameter int CNT_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      step,
   input  logic signed [DATA_W-1:0]  z0_re,
   input  logic signed [DATA_W-1:0]  z0_im,
   input  logic signed [DATA_W-1:0]  k_re,
   input  logic signed [DATA_W-1:0]  k_im,
   output logic [CNT_W-1:0]          count,
   output logic                      finished
);

   localparam int PW = 2 * DATA_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic signed [PW-1:0] ESC_LIM = PW'(4) <<< FRAC_W;

   logic signed [DATA_W-1:0] zr_q, zi_q;
   logic [CNT_W-1:0]         cnt_q;

   logic signed [PW-1:0] wr, wi, wkr, wki;
   logic signed [PW-1:0] p_rr, p_ii, p_ri;
   logic signed [PW-1:0] sq_r, sq_i, cross2, mag;
   logic signed [PW-1:0] new_r_w, new_i_w;
   logic                 escaped;

   assign wr  = {{DATA_W{zr_q[DATA_W-1]}}, zr_q};
   assign wi  = {{DATA_W{zi_q[DATA_W-1]}}, zi_q};
   assign wkr = {{DATA_W{k_re[DATA_W-1]}}, k_re};
   assign wki = {{DATA_W{k_im[DATA_W-1]}}, k_im};

   assign p_rr   = wr * wr;
   assign p_ii   = wi * wi;
   assign p_ri   = wr * wi;
   assign sq_r   = p_rr >>> FRAC_W;
   assign sq_i   = p_ii >>> FRAC_W;
   assign cross2 = p_ri >>> (FRAC_W - 1);
   assign mag    = sq_r + sq_i;
   assign escaped = (mag > ESC_LIM);

   assign new_r_w = sq_r - sq_i + wkr;
   assign new_i_w = cross2 + wki;

   assign finished = escaped || (cnt_q == CNT_MAX);
   assign count    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zr_q  <= '0;
         zi_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         zr_q  <= z0_re;
         zi_q  <= z0_im;
         cnt_q <= '0;
      end else if (step && !finished) begin
         zr_q  <= new_r_w[DATA_W-1:0];
         zi_q  <= new_i_w[DATA_W-1:0];
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/julia_engine.sv
module julia_engine #(
   parameter int DATA_W  = 16,
   parameter int FRAC_W  = 12,
   parameter int CNT_W   = 8,
   parameter int COORD_W = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [COORD_W-1:0]        width,
   input  logic [COORD_W-1:0]        height,
   input  logic signed [DATA_W-1:0]  step_x,
   input  logic signed [DATA_W-1:0]  step_y,
   input  logic signed [DATA_W-1:0]  c_re,
   input  logic signed [DATA_W-1:0]  c_im,
   output logic                      pix_valid,
   input  logic                      pix_ready,
   output logic [COORD_W-1:0]        pix_x,
   output logic [COORD_W-1:0]        pix_y,
   output logic [CNT_W-1:0]          pix_r,
   output logic [CNT_W-1:0]          pix_g,
   output logic [CNT_W-1:0]          pix_b,
   output logic                      done
);
   import julia_pkg::*;

   if (FRAC_W < 2 || FRAC_W > DATA_W - 4) begin : g_bad_frac
      $error("julia_engine: FRAC_W must leave at least 4 integer bits");
   end
   if (CNT_W < 1 || COORD_W < 1) begin : g_bad_width
      $error("julia_engine: CNT_W and COORD_W must be positive");
   end

   eng_state_e state_q, state_d;

   logic [COORD_W-1:0]       w_q, h_q;
   logic signed [DATA_W-1:0] sx_q, sy_q, cre_q, cim_q;

   logic                     accept_start, handshake;
   logic                     scan_restart, scan_adv, scan_last;
   logic [COORD_W-1:0]       col_idx, row_idx;
   logic signed [DATA_W-1:0] nxt_re, nxt_im;
   logic                     it_load, it_step, it_fin;
   logic [CNT_W-1:0]         it_cnt;
   logic [CNT_W-1:0]         chan [NUM_CHAN];

   assign accept_start = (state_q == ST_IDLE) && start;
   assign handshake    = (state_q == ST_OUT) && pix_ready;

   assign scan_restart = accept_start;
   assign scan_adv     = handshake && !scan_last;
   assign it_load      = accept_start || scan_adv;
   assign it_step      = (state_q == ST_ITER);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_ITER;
         ST_ITER: if (it_fin) state_d = ST_OUT;
         ST_OUT:  if (pix_ready) state_d = scan_last ? ST_DONE : ST_ITER;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         w_q     <= '0;
         h_q     <= '0;
         sx_q    <= '0;
         sy_q    <= '0;
         cre_q   <= '0;
         cim_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept_start) begin
            w_q   <= width;
            h_q   <= height;
            sx_q  <= step_x;
            sy_q  <= step_y;
            cre_q <= c_re;
            cim_q <= c_im;
         end
      end
   end

   julia_scan #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W),
      .COORD_W(COORD_W)
   ) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(scan_restart),
      .advance(scan_adv),
      .cols   (w_q),
      .rows   (h_q),
      .inc_x  (sx_q),
      .inc_y  (sy_q),
      .col_idx(col_idx),
      .row_idx(row_idx),
      .nxt_re (nxt_re),
      .nxt_im (nxt_im),
      .at_last(scan_last)
   );

   julia_iter #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .CNT_W (CNT_W)
   ) u_iter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (it_load),
      .step    (it_step),
      .z0_re   (nxt_re),
      .z0_im   (nxt_im),
      .k_re    (accept_start ? c_re : cre_q),
      .k_im    (accept_start ? c_im : cim_q),
      .count   (it_cnt),
      .finished(it_fin)
   );

   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      assign chan[ch] = it_cnt;
   end

   assign pix_valid = (state_q == ST_OUT);
   assign done      = (state_q == ST_DONE);
   assign pix_x     = col_idx;
   assign pix_y     = row_idx;
   assign pix_r     = chan[0];
   assign pix_g     = chan[1];
   assign pix_b     = chan[2];

endmodule

// File: rtl/julia_engine_chk.sv
module julia_engine_chk #(
   parameter int CNT_W   = 8,
   parameter int COORD_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         state_q,
   input logic               it_fin,
   input logic [CNT_W-1:0]   it_cnt,
   input logic               pix_valid,
   input logic               pix_ready,
   input logic [COORD_W-1:0] pix_x,
   input logic [COORD_W-1:0] pix_y,
   input logic [CNT_W-1:0]   pix_r,
   input logic [CNT_W-1:0]   pix_g,
   input logic [CNT_W-1:0]   pix_b,
   input logic               done,
   input logic [COORD_W-1:0] w_q,
   input logic [COORD_W-1:0] h_q
);

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_r)))
      else $error("p_stall_hold_r7");

   p_grey_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_r == pix_g && pix_g == pix_b))
      else $error("p_grey_equal_r6");

   p_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_x < w_q && pix_y < h_q))
      else $error("p_in_frame_r2");

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("p_done_single_r8");

   p_done_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pix_valid)
      else $error("p_done_no_valid_r8");

   p_one_iter_per_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 2'd1 && !it_fin) |=> (it_cnt == $past(it_cnt) + 1'b1))
      else $error("p_one_iter_per_cycle_r11");

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |-> (!pix_valid && !done))
      else $error("p_reset_quiet_r10");

endmodule

bind julia_engine julia_engine_chk #(
   .CNT_W  (CNT_W),
   .COORD_W(COORD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state_q  (state_q),
   .it_fin   (it_fin),
   .it_cnt   (it_cnt),
   .pix_valid(pix_valid),
   .pix_ready(pix_ready),
   .pix_x    (pix_x),
   .pix_y    (pix_y),
   .pix_r    (pix_r),
   .pix_g    (pix_g),
   .pix_b    (pix_b),
   .done     (done),
   .w_q      (w_q),
   .h_q      (h_q)
);

// File: tb/tb_julia_engine.sv
module tb_julia_engine;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [9:0]        width = '0, height = '0;
   logic signed [15:0] step_x = '0, step_y = '0, c_re = '0, c_im = '0;
   logic              pix_valid, pix_ready = 1'b0;
   logic [9:0]        pix_x, pix_y;
   logic [7:0]        pix_r, pix_g, pix_b;
   logic              done;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   logic [7:0] lfsr = 8'hA5;

   always #10 clk = ~clk;

   julia_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
      .step_x(step_x), .step_y(step_y), .c_re(c_re), .c_im(c_im),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int t16(input longint v);
      shortint s;
      s = shortint'(v);
      return int'(s);
   endfunction

   function automatic int ref_count(input int x0, input int y0, input int cr, input int ci);
      longint x, y, sx, sy, xy;
      int cnt;
      x = x0; y = y0; cnt = 0;
      while (cnt < 255) begin
         sx = (x * x) >>> 12;
         sy = (y * y) >>> 12;
         if (sx + sy > 16384) break;
         xy = (x * y) >>> 11;
         x = t16(sx - sy + cr);
         y = t16(xy + ci);
         cnt++;
      end
      return cnt;
   endfunction

   task automatic run_frame(input int w, input int h, input int sx, input int sy,
                            input int cr, input int ci, input bit stall, input bit inject);
      int idx, gap, exp_cnt, m, n;
      bit prev_stall, seen, finished, expect_done;
      logic [9:0] hx, hy;
      logic [7:0] hr;
      @(negedge clk);
      width = 10'(w); height = 10'(h);
      step_x = 16'(sx); step_y = 16'(sy); c_re = 16'(cr); c_im = 16'(ci);
      start = 1'b1;
      pix_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      // R9: inputs changed after start must not matter
      width = 10'(w + 3); height = 10'(h + 2);
      step_x = 16'(sx + 100); c_re = 16'(cr + 777); c_im = 16'(ci - 333);
      idx = 0; gap = 1; prev_stall = 0; seen = 0; finished = 0; expect_done = 0;
      hx = '0; hy = '0; hr = '0;
      while (!finished) begin
         start = 1'b0;
         if (expect_done) begin
            check(done == 1'b1, "R8 done after last accept", int'(done), 1);
            check(pix_valid == 1'b0, "R8 valid low with done", int'(pix_valid), 0);
            @(negedge clk);
            check(done == 1'b0, "R8 done one cycle", int'(done), 0);
            finished = 1;
         end else begin
            if (done) check(1'b0, "R8 early done", 1, 0);
            if (prev_stall) begin
               check(pix_valid && pix_x == hx && pix_y == hy && pix_r == hr,
                     "R7 hold under stall", int'(pix_r), int'(hr));
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pix_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (pix_valid) begin
               if (!seen) begin
                  m = idx % w; n = idx / w;
                  exp_cnt = ref_count(-6144 + m * sx, -6144 + n * sy, cr, ci);
                  check(int'(pix_x) == m, "R2 column order", int'(pix_x), m);
                  check(int'(pix_y) == n, "R2 row order", int'(pix_y), n);
                  if (exp_cnt == 0)
                     check(int'(pix_r) == exp_cnt, "R4 escape before update", int'(pix_r), exp_cnt);
                  else if (exp_cnt == 255)
                     check(int'(pix_r) == exp_cnt, "R5 cap", int'(pix_r), exp_cnt);
                  else
                     check(int'(pix_r) == exp_cnt, "R3 iteration count", int'(pix_r), exp_cnt);
                  check(pix_g == pix_r && pix_b == pix_r, "R6 grey channels", int'(pix_b), int'(pix_r));
                  if (!stall)
                     check(gap == exp_cnt + 2, "R11 cycles per pixel", gap, exp_cnt + 2);
                  seen = 1;
               end
               if (inject && idx == 1) start = 1'b1;
               if (pix_ready) begin
                  idx++;
                  seen = 0;
                  gap = 0;
                  prev_stall = 0;
                  if (idx == w * h) expect_done = 1;
               end else begin
                  prev_stall = 1;
                  hx = pix_x; hy = pix_y; hr = pix_r;
               end
            end
            gap++;
            @(negedge clk);
         end
      end
      pix_ready = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(pix_valid == 1'b0 && done == 1'b0, "R9 idle after frame", int'(pix_valid), 0);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(pix_valid == 1'b0, "R10 reset valid", int'(pix_valid), 0);
      check(done == 1'b0, "R10 reset done", int'(done), 0);
      start = 1'b1;
      @(negedge clk);
      check(pix_valid == 1'b0, "R10 start held in reset", int'(pix_valid), 0);
      start = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(pix_valid == 1'b0 && done == 1'b0, "R10 idle after reset", int'(pix_valid), 0);

      // R1: single pixel at the window corner (-1.5,-1.5) escapes at once
      run_frame(1, 1, 1536, 2048, 504, 3052, 1'b0, 1'b0);
      // Default constant, free-running consumer, latency checked
      run_frame(8, 6, 1536, 2048, 504, 3052, 1'b0, 1'b0);
      // c = 0: interior of the unit circle reaches the cap, with back-pressure and a start while busy
      run_frame(5, 4, 2457, 3072, 0, 0, 1'b1, 1'b1);
      // Another constant with stalls
      run_frame(4, 4, 3072, 3072, -3072, 410, 1'b1, 1'b0);
      // Wide row, single row
      run_frame(12, 1, 1024, 0, -1024, 2048, 1'b0, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule